// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter

This block holds a wall-clock time and calendar as seven byte-wide fields: seconds, minutes, hours, weekday, day of month, month and two-digit year. An external once-per-second strobe makes the block advance the time by one second. The carry moves from field to field, one field per clock cycle, and stops at the first field that does not wrap. Every field is kept either in packed BCD or in plain binary, chosen by one mode bit. Hours are shown in 24-hour form or in 12-hour form with a PM flag. Day-of-month rollover follows the length of the month, and years divisible by four are leap years.

Software reaches the fields through one byte-addressed port. The same address drives a combinational read and a synchronous write. A control byte selects the encoding and the hour format and holds a freeze bit, so software can load a new time without it moving. The encoding bit does not convert the stored bytes, so software rewrites the fields after it changes a mode.

The sequencer has seven named states. ST_IDLE waits for the strobe. Each of ST_SEC, ST_MIN, ST_HOUR, ST_DATE, ST_MONTH and ST_YEAR advances its own field in one cycle. The transitions are: ST_IDLE to ST_SEC on a strobe while not frozen. From ST_SEC, ST_MIN, ST_HOUR, ST_DATE and ST_MONTH, the sequencer moves to the next state in that list when its field wraps, and to ST_IDLE when it does not. ST_YEAR always returns to ST_IDLE. ST_DATE also advances the weekday.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read 0x00 for seconds, minutes, hours and year and 0x01 for weekday, date and month. The control byte reads 0x02 (24-hour, BCD, running).
- R2: The field addresses are 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 weekday, 0x07 date, 0x08 month and 0x09 year. The control byte is at 0x0B, with bit 7 = freeze, bit 2 = binary mode and bit 1 = 24-hour mode, and its other bits read 0. Any other address reads 0x00, and a write to it changes nothing.
- R3: Bit 7 of the seconds field always reads 0, whatever is written to it.
- R4: A strobe in ST_IDLE while not frozen advances the seconds. Seconds and minutes run 0 to 59 and then wrap to 0 with a carry. `busy` is high for exactly one cycle per field visited: 1 + the number of wrapping fields, 6 at most.
- R5: In BCD mode (bit 2 = 0) each field holds tens in bits 7:4 and units in bits 3:0. In binary mode (bit 2 = 1) it holds the plain value, for example 10 seconds reads 0x0A.
- R6: In 24-hour mode the hours run 0 to 23. The wrap from 23 to 0 carries into the date.
- R7: In 12-hour mode bit 7 of the hours byte is PM and bits 6:0 hold 1 to 12. 11 rolls to 12 and toggles PM. 12 rolls to 1 with PM unchanged. Only 11 PM to 12 AM carries into the date.
- R8: The date wraps to 1 after 31 in months 1, 3, 5, 7, 8, 10 and 12, after 30 in months 4, 6, 9 and 11, and after 28 in month 2. When the year is divisible by 4, month 2 wraps after 29 instead.
- R9: The weekday runs 1 to 7, wraps to 1, and advances exactly when the date advances.
- R10: The month wraps from 12 to 1 with a carry into the year. The year wraps from 99 to 0.
- R11: While the freeze bit is set, strobes are ignored: `busy` stays low and no field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe, one cycle wide |
| wr_en | input | 1 | Write strobe for the addressed byte |
| addr | input | ADDR_W (7) | Byte address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the addressed byte |
| busy | output | 1 | High while the carry ripple is in progress |

## Verification
The assertions assume that software never writes while `busy` is high, and that a strobe never arrives during a ripple. Under that assumption, every step in a field state commits the value the step logic computed. The stimulus keeps within these limits: every strobe waits for `busy` to fall and for a few idle cycles before the next access. Every new time is loaded with the freeze bit set. A reference model of the calendar compares all eight readable bytes on each idle cycle. It also predicts how many cycles each ripple lasts, from the carries it expects.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NFLD = 7;
    localparam int FI_SEC  = 0;
    localparam int FI_MIN  = 1;
    localparam int FI_HOUR = 2;
    localparam int FI_DAY  = 3;
    localparam int FI_DATE = 4;
    localparam int FI_MON  = 5;
    localparam int FI_YEAR = 6;
    localparam logic [7:0] A_CTRL = 8'h0B;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DATE, ST_MONTH, ST_YEAR
    } step_e;

    typedef logic [NFLD-1:0][7:0] fld_vec_t;

    function automatic logic [7:0] fld_addr(int i);
        case (i)
            FI_SEC:  return 8'h00;
            FI_MIN:  return 8'h02;
            FI_HOUR: return 8'h04;
            FI_DAY:  return 8'h06;
            FI_DATE: return 8'h07;
            FI_MON:  return 8'h08;
            default: return 8'h09;
        endcase
    endfunction

    function automatic logic [7:0] fld_reset(int i);
        return (i == FI_DAY || i == FI_DATE || i == FI_MON) ? 8'h01 : 8'h00;
    endfunction

    function automatic step_e fld_step(int i);
        case (i)
            FI_SEC:  return ST_SEC;
            FI_MIN:  return ST_MIN;
            FI_HOUR: return ST_HOUR;
            FI_DATE: return ST_DATE;
            FI_MON:  return ST_MONTH;
            FI_YEAR: return ST_YEAR;
            default: return ST_IDLE;
        endcase
    endfunction

    // encoded byte -> numeric value
    function automatic logic [6:0] fld_val(logic [7:0] b, logic bin);
        if (bin) return b[6:0];
        return 7'(({3'b0, b[7:4]} * 7'd10) + {3'b0, b[3:0]});
    endfunction

    // numeric value -> encoded byte
    function automatic logic [7:0] fld_enc(logic [6:0] n, logic bin);
        if (bin) return {1'b0, n};
        return {4'(n / 7'd10), 4'(n % 7'd10)};
    endfunction

    function automatic logic [6:0] month_len(logic [6:0] mon, logic [6:0] yr);
        case (mon)
            7'd2:                       return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
            default:                    return 7'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_step_fsm.sv
module rtc_step_fsm
    import rtc_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  hold,
    input  logic  wrap,
    output step_e state,
    output logic  busy
);

    step_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tick && !hold) state_d = ST_SEC;
            ST_SEC:   state_d = wrap ? ST_MIN   : ST_IDLE;
            ST_MIN:   state_d = wrap ? ST_HOUR  : ST_IDLE;
            ST_HOUR:  state_d = wrap ? ST_DATE  : ST_IDLE;
            ST_DATE:  state_d = wrap ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_d = wrap ? ST_YEAR  : ST_IDLE;
            ST_YEAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        state = state_q;
        busy  = (state_q != ST_IDLE);
    end

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && tick && !hold) |=> (state_q == ST_SEC));
    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hold) |=> (state_q == ST_IDLE));
    p_sec_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC && wrap) |=> (state_q == ST_MIN));
    p_year_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_YEAR) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/rtc_step_calc.sv
module rtc_step_calc
    import rtc_cal_pkg::*;
(
    input  step_e      state,
    input  logic       bin,
    input  logic       h24,
    input  fld_vec_t   fv,
    output logic [7:0] nv,
    output logic [7:0] day_nv,
    output logic       wrap
);

    logic [6:0] v, lim, dv;
    logic       pm;
    logic [7:0] enc;

    always_comb begin
        nv     = 8'h00;
        day_nv = fv[FI_DAY];
        wrap   = 1'b0;
        v      = 7'd0;
        dv     = 7'd0;
        lim    = 7'd0;
        pm     = 1'b0;
        enc    = 8'h00;
        unique case (state)
            ST_IDLE: ;
            ST_SEC, ST_MIN: begin
                v = fld_val(fv[(state == ST_SEC) ? FI_SEC : FI_MIN], bin);
                if (v >= 7'd59) begin v = 7'd0; wrap = 1'b1; end
                else            v = v + 7'd1;
                nv = fld_enc(v, bin);
            end
            ST_HOUR: begin
                if (h24) begin
                    v = fld_val(fv[FI_HOUR], bin);
                    if (v >= 7'd23) begin v = 7'd0; wrap = 1'b1; end
                    else            v = v + 7'd1;
                    nv = fld_enc(v, bin);
                end else begin
                    pm = fv[FI_HOUR][7];
                    v  = fld_val({1'b0, fv[FI_HOUR][6:0]}, bin);
                    if (v == 7'd11) begin
                        v    = 7'd12;
                        wrap = pm;
                        pm   = ~pm;
                    end else if (v >= 7'd12) begin
                        v = 7'd1;
                    end else begin
                        v = v + 7'd1;
                    end
                    enc = fld_enc(v, bin);
                    nv  = {pm, enc[6:0]};
                end
            end
            ST_DATE: begin
                lim = month_len(fld_val(fv[FI_MON], bin), fld_val(fv[FI_YEAR], bin));
                v   = fld_val(fv[FI_DATE], bin);
                if (v >= lim) begin v = 7'd1; wrap = 1'b1; end
                else          v = v + 7'd1;
                nv = fld_enc(v, bin);
                dv = fld_val(fv[FI_DAY], bin);
                dv = (dv >= 7'd7) ? 7'd1 : dv + 7'd1;
                day_nv = fld_enc(dv, bin);
            end
            ST_MONTH: begin
                v = fld_val(fv[FI_MON], bin);
                if (v >= 7'd12) begin v = 7'd1; wrap = 1'b1; end
                else            v = v + 7'd1;
                nv = fld_enc(v, bin);
            end
            ST_YEAR: begin
                v = fld_val(fv[FI_YEAR], bin);
                if (v >= 7'd99) begin v = 7'd0; wrap = 1'b1; end
                else            v = v + 7'd1;
                nv = fld_enc(v, bin);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  step_e             state,
    input  logic [7:0]        nv,
    input  logic [7:0]        day_nv,
    output fld_vec_t          fv,
    output logic              hold,
    output logic              bin,
    output logic              h24,
    output logic [7:0]        rd_data
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(A_CTRL);

    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        localparam logic [ADDR_W-1:0] MY_A   = ADDR_W'(fld_addr(i));
        localparam logic [7:0]        MY_RST = fld_reset(i);
        localparam step_e             MY_ST  = fld_step(i);
        logic [7:0] q;
        logic       hit;
        assign hit = wr_en && (addr == MY_A);

        if (i == FI_DAY) begin : g_day
            always_ff @(posedge clk) begin
                if (!rst_n)                 q <= MY_RST;
                else if (hit)               q <= wr_data;
                else if (state == ST_DATE)  q <= day_nv;
            end
        end else if (i == FI_SEC) begin : g_sec
            always_ff @(posedge clk) begin
                if (!rst_n)                 q <= MY_RST;
                else if (hit)               q <= {1'b0, wr_data[6:0]};
                else if (state == MY_ST)    q <= {1'b0, nv[6:0]};
            end
        end else begin : g_gen
            always_ff @(posedge clk) begin
                if (!rst_n)                 q <= MY_RST;
                else if (hit)               q <= wr_data;
                else if (state == MY_ST)    q <= nv;
            end
        end
        assign fv[i] = q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= 1'b0;
            bin  <= 1'b0;
            h24  <= 1'b1;
        end else if (wr_en && addr == CTRL_A) begin
            hold <= wr_data[7];
            bin  <= wr_data[2];
            h24  <= wr_data[1];
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NFLD; i++)
            if (addr == ADDR_W'(fld_addr(i))) rd_data = fv[i];
        if (addr == CTRL_A) rd_data = {hold, 4'b0000, bin, h24, 1'b0};
    end

    p_sec_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(fld_addr(FI_SEC))) |=> (fv[FI_SEC][7] == 1'b0));
    p_sec_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEC && !wr_en) |=> !$stable(fv[FI_SEC]));
    p_day_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATE && !wr_en) |=> (fv[FI_DAY] >= 8'd1 && fv[FI_DAY] <= 8'd7));
    p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_A) |=> (bin == $past(wr_data[2]) && h24 == $past(wr_data[1])));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              busy
);

    step_e      state;
    logic       wrap, hold, bin, h24;
    logic [7:0] nv, day_nv;
    fld_vec_t   fv;

    rtc_step_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hold  (hold),
        .wrap  (wrap),
        .state (state),
        .busy  (busy)
    );

    rtc_step_calc u_calc (
        .state  (state),
        .bin    (bin),
        .h24    (h24),
        .fv     (fv),
        .nv     (nv),
        .day_nv (day_nv),
        .wrap   (wrap)
    );

    rtc_cal_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .state   (state),
        .nv      (nv),
        .day_nv  (day_nv),
        .fv      (fv),
        .hold    (hold),
        .bin     (bin),
        .h24     (h24),
        .rd_data (rd_data)
    );

endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/100ps
module tb_rtc_calendar_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] addr = 7'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    // reference model: plain integers, hour kept 0..23
    int ms, mm, mh, mdw, mdt, mmo, myr;
    bit mbin, mh24, mhold;

    always #2 clk = ~clk;

    rtc_calendar_core dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [7:0] enc(int n);
        if (mbin) return 8'(n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic [7:0] enc_hour();
        int h12;
        logic [7:0] b;
        if (mh24) return enc(mh);
        h12 = (mh % 12 == 0) ? 12 : mh % 12;
        b = enc(h12);
        return {(mh >= 12) ? 1'b1 : 1'b0, b[6:0]};
    endfunction

    function automatic int mlen(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] ctrl_byte();
        return {mhold, 4'b0000, mbin, mh24, 1'b0};
    endfunction

    function automatic logic [7:0] exp_at(int a);
        case (a)
            'h00: return enc(ms);
            'h02: return enc(mm);
            'h04: return enc_hour();
            'h06: return enc(mdw);
            'h07: return enc(mdt);
            'h08: return enc(mmo);
            'h09: return enc(myr);
            'h0B: return ctrl_byte();
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(logic [7:0] got, logic [7:0] exp, string req, int a);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr %02h actual %02h expected %02h", req, a, got, exp);
        end
    endtask

    task automatic check_all(string req);
        int lst[8] = '{'h00, 'h02, 'h04, 'h06, 'h07, 'h08, 'h09, 'h0B};
        for (int k = 0; k < 8; k++) begin
            addr = 7'(lst[k]);
            #0.1;
            chk(rd_data, exp_at(lst[k]), req, lst[k]);
        end
    endtask

    // every clock while the main thread is idle
    always @(negedge clk) if (mon_en) check_all("R2");

    task automatic idle(int n);
        mon_en = 1'b1;
        repeat (n) @(negedge clk);
        #1;
        mon_en = 1'b0;
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        addr = 7'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(int a, logic [7:0] exp, string req);
        @(negedge clk);
        addr = 7'(a);
        #0.1;
        chk(rd_data, exp, req, a);
    endtask

    task automatic setup(bit b, bit h, int s, int m, int hr, int dw, int dt, int mo, int yr);
        mhold = 1'b1; mbin = b; mh24 = h;
        wr('h0B, ctrl_byte());
        ms = s; mm = m; mh = hr; mdw = dw; mdt = dt; mmo = mo; myr = yr;
        wr('h00, enc(ms)); wr('h02, enc(mm)); wr('h04, enc_hour());
        wr('h06, enc(mdw)); wr('h07, enc(mdt)); wr('h08, enc(mmo)); wr('h09, enc(myr));
        mhold = 1'b0;
        wr('h0B, ctrl_byte());
    endtask

    task automatic m_advance();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mdw = (mdw == 7) ? 1 : mdw + 1;
                    mdt++;
                    if (mdt > mlen(mmo, myr)) begin
                        mdt = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1;
                            myr = (myr == 99) ? 0 : myr + 1;
                        end
                    end
                end
            end
        end
    endtask

    task automatic do_tick(string req);
        int n_exp, cnt;
        n_exp = 0;
        if (!mhold) begin
            n_exp = 1;
            if (ms == 59) begin
                n_exp++;
                if (mm == 59) begin
                    n_exp++;
                    if (mh == 23) begin
                        n_exp++;
                        if (mdt == mlen(mmo, myr)) begin
                            n_exp++;
                            if (mmo == 12) n_exp++;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        cnt = 0;
        while (busy === 1'b1 && cnt < 20) begin
            cnt++;
            @(negedge clk);
        end
        n_chk++;
        if (cnt != n_exp) begin
            n_bad++;
            $display("FAIL R4 busy cycles actual %0d expected %0d", cnt, n_exp);
        end
        if (!mhold) m_advance();
        check_all(req);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        ms = 0; mm = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; myr = 0;
        mbin = 1'b0; mh24 = 1'b1; mhold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        rd_chk('h0B, 8'h02, "R1");
        idle(4);

        // R2: unmapped address ignored, control readback
        wr('h05, 8'hAA);
        rd_chk('h05, 8'h00, "R2");
        wr('h0A, 8'h55);
        rd_chk('h0A, 8'h00, "R2");
        @(negedge clk); check_all("R2");
        wr('h0B, 8'hFF);
        rd_chk('h0B, 8'h86, "R2");

        // R3: seconds MSB forced to 0
        setup(0, 1, 0, 0, 0, 1, 1, 1, 0);
        wr('h00, 8'hD9); ms = 59;
        rd_chk('h00, 8'h59, "R3");
        do_tick("R4");
        rd_chk('h00, 8'h00, "R4");
        rd_chk('h02, 8'h01, "R4");
        idle(3);

        // R10/R9/R6: full ripple to new century
        setup(0, 1, 58, 59, 23, 7, 31, 12, 99);
        do_tick("R4");
        do_tick("R10");
        rd_chk('h09, 8'h00, "R10");
        rd_chk('h08, 8'h01, "R10");
        rd_chk('h06, 8'h01, "R9");
        rd_chk('h04, 8'h00, "R6");
        idle(3);

        // R8: month lengths and leap years
        setup(0, 1, 59, 59, 23, 3, 28, 2, 24);
        do_tick("R8");
        rd_chk('h07, 8'h29, "R8");
        setup(0, 1, 59, 59, 23, 3, 29, 2, 24);
        do_tick("R8");
        rd_chk('h08, 8'h03, "R8");
        setup(0, 1, 59, 59, 23, 3, 28, 2, 23);
        do_tick("R8");
        rd_chk('h07, 8'h01, "R8");
        setup(0, 1, 59, 59, 23, 4, 30, 4, 10);
        do_tick("R8");
        setup(0, 1, 59, 59, 23, 5, 30, 1, 10);
        do_tick("R8");
        rd_chk('h07, 8'h31, "R8");
        do_tick("R8");

        // R7: 12-hour mode in BCD
        setup(0, 0, 59, 59, 11, 2, 10, 6, 5);
        do_tick("R7");
        rd_chk('h04, 8'h92, "R7");
        setup(0, 0, 59, 59, 12, 2, 10, 6, 5);
        do_tick("R7");
        rd_chk('h04, 8'h81, "R7");
        setup(0, 0, 59, 59, 23, 2, 10, 6, 5);
        do_tick("R7");
        rd_chk('h04, 8'h12, "R7");
        rd_chk('h07, 8'h11, "R7");
        setup(0, 0, 59, 59, 0, 2, 10, 6, 5);
        do_tick("R7");
        rd_chk('h04, 8'h01, "R7");

        // R5: binary encoding
        setup(1, 1, 9, 0, 0, 1, 1, 1, 0);
        do_tick("R5");
        rd_chk('h00, 8'h0A, "R5");
        setup(1, 1, 59, 59, 23, 7, 31, 12, 99);
        do_tick("R5");
        setup(1, 0, 59, 59, 23, 1, 28, 2, 44);
        do_tick("R5");
        rd_chk('h04, 8'h0C, "R5");
        rd_chk('h07, 8'h1D, "R5");
        wr('h00, 8'hBB); ms = 59;
        rd_chk('h00, 8'h3B, "R3");

        // R11: frozen counter ignores strobes
        setup(0, 1, 30, 15, 10, 4, 15, 7, 33);
        mhold = 1'b1;
        wr('h0B, ctrl_byte());
        do_tick("R11");
        do_tick("R11");
        mhold = 1'b0;
        wr('h0B, ctrl_byte());
        do_tick("R11");
        idle(3);

        // long run through minute, hour and day carries, 24h BCD then 12h binary
        setup(0, 1, 0, 58, 23, 6, 30, 11, 19);
        for (int k = 0; k < 130; k++) begin
            do_tick("R4");
            idle(2);
        end
        setup(1, 0, 50, 59, 11, 6, 30, 11, 19);
        for (int k = 0; k < 30; k++) begin
            do_tick("R7");
            idle(2);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule